// File: doc/BRIEF.md
# JTAG Bit-Sequence Shift Engine

The engine runs one burst of 1 to 64 TCK cycles against a JTAG target. It takes a request with a clock count, a TMS level and a capture flag. TMS is held at that level for the whole burst. TDI bits are pulled from a byte-wide input stream, and TDO samples are packed into bytes on a byte-wide output stream.

TCK is derived from the system clock. Each half of a TCK period lasts a programmable number of system cycles. In every bit period the engine first drives TDI with TCK low. At the end of the low half it samples TDO, and it then holds TCK high for the high half.

The engine stalls with TCK low whenever it needs a TDI byte that has not arrived, or has a finished TDO byte and no free output slot. A stall never loses a bit and never repeats one. When the whole request is complete, a one-cycle done pulse is raised.

Top module: `jtag_shift_engine`

## Requirements
- R1: A request is accepted by `start` only while idle. It produces exactly N rising TCK edges, where N equals `req_len`, except that a `req_len` of 0 gives 64.
- R2: `tms` takes the value of `req_tms` when the request is accepted, and does not change while the burst runs.
- R3: TDI bit i of the burst is bit (i mod 8) of input byte floor(i/8), so bits are taken LSB first and bytes in arrival order. Exactly ceil(N/8) input bytes are consumed, and `din_ready` is high only while the engine waits for a byte.
- R4: TCK stays high for exactly H system cycles in every period, and stays low for at least H cycles before each rising edge. H is `half_period` latched at acceptance, and a value of 0 behaves as 1.
- R5: The `tdo` level in the system cycle just before each rising TCK edge is captured. Capture i goes to bit (i mod 8) of output byte floor(i/8).
- R6: Output bytes are emitted only when `req_capture` was set, and then exactly ceil(N/8) of them.
- R7: When N is not a multiple of 8, the final byte is still emitted, with its unused upper bits forced to zero.
- R8: While `din_ready` is high, or while a completed TDO byte waits for the output slot, TCK and TDI are both low. Stalls never drop or repeat a bit.
- R9: While `busy` is low, TCK and TDI are low.
- R10: `done` is high for exactly one cycle per request, after the last rising TCK edge and after the final byte has entered the output slot. `busy` is low in that cycle.
- R11: While `cap_valid` is high and `cap_ready` is low, `cap_valid` stays high and `cap_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, honoured only while idle |
| req_len | input | LEN_W | Clock count of the request, 0 means 2^LEN_W |
| req_tms | input | 1 | TMS level for the burst |
| req_capture | input | 1 | Emit packed TDO bytes when set |
| half_period | input | HP_W | Half-period of TCK in system cycles |
| din_valid | input | 1 | TDI byte available |
| din_data | input | 8 | TDI byte, LSB shifted first |
| din_ready | output | 1 | Engine takes a TDI byte this cycle |
| tdo | input | 1 | Test data from the target |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the target |
| cap_valid | output | 1 | Captured byte available |
| cap_data | output | 8 | Captured byte, first sample in bit 0 |
| cap_ready | input | 1 | Consumer takes the captured byte |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Several rules are checked by assertions on every cycle: the idle and stall pin levels, TMS stability during a burst, hold of the output byte under backpressure, and the shape of the done pulse. Other properties can only be shown by the bench's scenarios: edge count, bit order, TDO packing, zero fill of a partial byte, the half-period widths, and lossless behaviour under input gaps and output backpressure. These need a target model and recorded streams. The scenarios cover a full byte, the 64-clock maximum, a 13-bit burst, a burst without capture and a zero half-period, and a burst run with gaps and backpressure.

// File: rtl/jse_pkg.sv
package jse_pkg;
    localparam int BYTE_W = 8;
    localparam int POS_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOW,
        ST_HIGH,
        ST_EMIT
    } jse_state_e;
endpackage

// File: rtl/jse_half_timer.sv
module jse_half_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] period,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = period - W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/jse_cap_slot.sv
module jse_cap_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] data,
    output logic         free
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    assign free = !slot_q.valid || ready;

    always_comb begin
        slot_d = slot_q;
        if (load) begin
            slot_d.valid = 1'b1;
            slot_d.data  = load_data;
        end else if (ready) begin
            slot_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign valid = slot_q.valid;
    assign data  = slot_q.data;
endmodule

// File: rtl/jtag_shift_engine.sv
module jtag_shift_engine
    import jse_pkg::*;
#(
    parameter int HP_W  = 8,
    parameter int LEN_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_tms,
    input  logic              req_capture,
    input  logic [HP_W-1:0]   half_period,
    input  logic              din_valid,
    input  logic [BYTE_W-1:0] din_data,
    output logic              din_ready,
    input  logic              tdo,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    output logic              cap_valid,
    output logic [BYTE_W-1:0] cap_data,
    input  logic              cap_ready,
    output logic              busy,
    output logic              done
);
    localparam int CNT_W    = LEN_W + 1;
    localparam int MAX_BITS = 1 << LEN_W;

    typedef struct packed {
        jse_state_e        st;
        logic [CNT_W-1:0]  bits;
        logic [CNT_W-1:0]  total;
        logic              tms;
        logic              cap;
        logic [HP_W-1:0]   hp;
        logic [BYTE_W-1:0] sh_in;
        logic [BYTE_W-1:0] sh_out;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             tmr_load, tmr_expired;
    logic             slot_load, slot_free;
    logic [POS_W-1:0] pos;
    logic             last_bit, byte_end;

    assign pos      = ctl_q.bits[POS_W-1:0];
    assign last_bit = (ctl_q.bits == ctl_q.total - CNT_W'(1));
    assign byte_end = (pos == POS_W'(BYTE_W - 1)) || last_bit;

    jse_half_timer #(.W(HP_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .period  (ctl_q.hp),
        .expired (tmr_expired)
    );

    jse_cap_slot #(.W(BYTE_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (slot_load),
        .load_data (ctl_q.sh_out),
        .ready     (cap_ready),
        .valid     (cap_valid),
        .data      (cap_data),
        .free      (slot_free)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        slot_load  = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.total  = (req_len == '0) ? CNT_W'(MAX_BITS) : {1'b0, req_len};
                    ctl_d.tms    = req_tms;
                    ctl_d.cap    = req_capture;
                    ctl_d.hp     = (half_period == '0) ? HP_W'(1) : half_period;
                    ctl_d.bits   = '0;
                    ctl_d.sh_out = '0;
                    ctl_d.st     = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (din_valid) begin
                    ctl_d.sh_in = din_data;
                    ctl_d.st    = ST_LOW;
                    tmr_load    = 1'b1;
                end
            end
            ST_LOW: begin
                if (tmr_expired) begin
                    ctl_d.sh_out[pos] = tdo;
                    ctl_d.st          = ST_HIGH;
                    tmr_load          = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tmr_expired) begin
                    ctl_d.bits = ctl_q.bits + CNT_W'(1);
                    if (ctl_q.cap && byte_end) begin
                        ctl_d.st = ST_EMIT;
                    end else begin
                        if (byte_end) ctl_d.sh_out = '0;
                        if (last_bit) begin
                            ctl_d.st   = ST_IDLE;
                            ctl_d.done = 1'b1;
                        end else if (byte_end) begin
                            ctl_d.st = ST_FETCH;
                        end else begin
                            ctl_d.st = ST_LOW;
                            tmr_load = 1'b1;
                        end
                    end
                end
            end
            ST_EMIT: begin
                if (slot_free) begin
                    slot_load    = 1'b1;
                    ctl_d.sh_out = '0;
                    if (ctl_q.bits == ctl_q.total) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.st = ST_FETCH;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = (ctl_q.st != ST_IDLE);
    assign din_ready = (ctl_q.st == ST_FETCH);
    assign tck       = (ctl_q.st == ST_HIGH);
    assign tdi       = ((ctl_q.st == ST_LOW) || (ctl_q.st == ST_HIGH)) && ctl_q.sh_in[pos];
    assign tms       = ctl_q.tms;
    assign done      = ctl_q.done;
endmodule

// File: rtl/jse_checker.sv
module jse_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       tck,
    input logic       tms,
    input logic       tdi,
    input logic       din_ready,
    input logic       cap_valid,
    input logic [7:0] cap_data,
    input logic       cap_ready,
    input logic       done
);
    p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tck && !tdi));

    p_stall_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        din_ready |-> (!tck && !tdi));

    p_ready_only_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        din_ready |-> busy);

    p_tms_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(tms));

    p_cap_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !cap_ready) |=> (cap_valid && $stable(cap_data)));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind jtag_shift_engine jse_checker u_jse_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .tck       (tck),
    .tms       (tms),
    .tdi       (tdi),
    .din_ready (din_ready),
    .cap_valid (cap_valid),
    .cap_data  (cap_data),
    .cap_ready (cap_ready),
    .done      (done)
);

// File: tb/jtag_shift_engine_bench.sv
`timescale 1ns/1ps
module jtag_shift_engine_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [5:0] req_len = '0;
    logic       req_tms = 1'b0;
    logic       req_capture = 1'b0;
    logic [7:0] half_period = 8'd1;
    logic       din_valid = 1'b0;
    logic [7:0] din_data = '0;
    logic       din_ready;
    logic       tdo_pin;
    logic       tck, tms, tdi;
    logic       cap_valid;
    logic [7:0] cap_data;
    logic       cap_ready = 1'b1;
    logic       busy, done;

    always #2 clk = ~clk;

    jtag_shift_engine u_jtag_shift_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .req_len(req_len),
        .req_tms(req_tms), .req_capture(req_capture), .half_period(half_period),
        .din_valid(din_valid), .din_data(din_data), .din_ready(din_ready),
        .tdo(tdo_pin), .tck(tck), .tms(tms), .tdi(tdi),
        .cap_valid(cap_valid), .cap_data(cap_data), .cap_ready(cap_ready),
        .busy(busy), .done(done)
    );

    int total_checks = 0;
    int failed_checks = 0;

    // run configuration, written only by the tasks
    int          run_id = 0;
    logic [63:0] tdi_vec = '0;
    logic [63:0] tpat = '0;
    int          nbytes_in = 0;
    int          exp_n = 0;
    int          exp_hp = 1;
    bit          exp_tms = 1'b0;
    bit          gap_mode = 1'b0;
    bit          bp_mode = 1'b0;

    // observations, written only by the monitor
    int          seen_id = 0;
    int          rises = 0;
    logic [63:0] rx_tdi = '0;
    int          tms_err = 0, hi_err = 0, lo_err = 0, stall_err = 0, idle_err = 0;
    int          hold_err = 0, done_cnt = 0, done_early = 0;
    int          hi_len = 0, lo_len = 0;
    int          in_idx = 0, cap_cnt = 0, ctr = 0;
    logic [7:0]  cap_bytes [8];
    bit          feed_acc = 1'b0, tck_prev = 1'b0;
    bit          hv = 1'b0, hr = 1'b0;
    logic [7:0]  hd = '0;

    assign tdo_pin = (rises < 64) ? tpat[rises[5:0]] : 1'b0;

    always @(negedge clk) begin
        if (run_id != seen_id) begin
            seen_id = run_id;
            rises = 0; rx_tdi = '0; tms_err = 0; hi_err = 0; lo_err = 0;
            stall_err = 0; idle_err = 0; hold_err = 0; done_cnt = 0;
            done_early = 0; hi_len = 0; lo_len = 0; in_idx = 0; cap_cnt = 0;
            feed_acc = 1'b0;
            for (int k = 0; k < 8; k++) cap_bytes[k] = '0;
        end
        ctr = ctr + 1;
        // pin monitor
        if (tck && !tck_prev) begin
            if (rises < 64) rx_tdi[rises] = tdi;
            if (tms !== exp_tms) tms_err++;
            if (lo_len < exp_hp) lo_err++;
            lo_len = 0;
            rises++;
        end
        if (tck) hi_len++;
        else begin
            if (tck_prev && hi_len != exp_hp) hi_err++;
            hi_len = 0;
            if (busy) lo_len++;
        end
        tck_prev = tck;
        if (din_ready && (tck || tdi)) stall_err++;
        if (!busy && (tck || tdi)) idle_err++;
        if (done) begin
            done_cnt++;
            if (rises != exp_n) done_early++;
        end
        // output stream hold check and consumer
        if (hv && !hr && (!cap_valid || cap_data !== hd)) hold_err++;
        cap_ready = !(bp_mode && ctr[2:1] != 2'b00);
        if (cap_valid && cap_ready) begin
            if (cap_cnt < 8) cap_bytes[cap_cnt] = cap_data;
            cap_cnt++;
        end
        hv = cap_valid; hr = cap_ready; hd = cap_data;
        // input stream producer
        if (feed_acc) in_idx++;
        din_valid = (in_idx < nbytes_in) && !(gap_mode && ctr[1]);
        din_data  = (in_idx < 8) ? tdi_vec[in_idx*8 +: 8] : 8'h00;
        feed_acc  = din_valid && din_ready;
    end

    task automatic chk(input string req, input int act, input int exp);
        total_checks++;
        if (act != exp) begin
            failed_checks++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        chk("R9 reset tck", int'(tck), 0);
        chk("R9 reset tdi", int'(tdi), 0);
        chk("R10 reset busy", int'(busy), 0);
        chk("R10 reset done", int'(done), 0);
        chk("R6 reset cap_valid", int'(cap_valid), 0);
        chk("R3 reset din_ready", int'(din_ready), 0);
    endtask

    task automatic run_seq(input string name, input int lenf, input bit tms_v,
                           input bit cap_v, input int hp, input logic [63:0] tdi_v,
                           input logic [63:0] tdo_v, input bit gap, input bit bp);
        int n, nb, mism, wait_cnt;
        logic [7:0] expb;
        n  = (lenf == 0) ? 64 : lenf;
        nb = (n + 7) / 8;
        @(posedge clk); #1;
        tdi_vec = tdi_v; tpat = tdo_v; nbytes_in = nb; exp_n = n;
        exp_hp = (hp == 0) ? 1 : hp; exp_tms = tms_v;
        gap_mode = gap; bp_mode = bp;
        run_id = run_id + 1;
        @(posedge clk); #1;
        req_len = 6'(lenf); req_tms = tms_v; req_capture = cap_v;
        half_period = 8'(hp); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_cnt = 0;
        while (done_cnt == 0 && wait_cnt < 20000) begin
            @(posedge clk); #1;
            wait_cnt++;
        end
        repeat (12) @(posedge clk);
        #1;
        $display("scenario %s", name);
        chk("R1 rising edge count", rises, n);
        chk("R2 tms held", tms_err, 0);
        mism = 0;
        for (int k = 0; k < n; k++) if (rx_tdi[k] !== tdi_v[k]) mism++;
        chk("R3 tdi bit order", mism, 0);
        chk("R3 input bytes consumed", in_idx, nb);
        chk("R4 tck high width", hi_err, 0);
        chk("R4 tck low width", lo_err, 0);
        chk("R6 output byte count", cap_cnt, cap_v ? nb : 0);
        if (cap_v) begin
            for (int k = 0; k < nb && k < 8; k++) begin
                expb = '0;
                for (int j = 0; j < 8; j++) if (8*k + j < n) expb[j] = tdo_v[8*k + j];
                if ((n % 8) != 0 && k == nb - 1)
                    chk("R7 partial byte zero fill", int'(cap_bytes[k]), int'(expb));
                else
                    chk("R5 packed tdo byte", int'(cap_bytes[k]), int'(expb));
            end
        end
        chk("R8 stall pins low", stall_err, 0);
        chk("R9 idle pins low", idle_err, 0);
        chk("R10 done pulses", done_cnt, 1);
        chk("R10 done after last edge", done_early, 0);
        chk("R11 output hold", hold_err, 0);
        chk("R10 busy cleared", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        t_reset();
        run_seq("full_byte", 8, 1'b1, 1'b1, 2, 64'hA5, 64'h3C, 1'b0, 1'b0);
        run_seq("max_len", 0, 1'b0, 1'b1, 1, 64'h0123_4567_89AB_CDEF,
                64'hF0E1_D2C3_B4A5_9687, 1'b0, 1'b0);
        run_seq("partial", 13, 1'b1, 1'b1, 3, 64'h1ABC, 64'hFFFF_FFFF_FFFF_FFFF,
                1'b0, 1'b0);
        run_seq("no_capture_hp0", 5, 1'b0, 1'b0, 0, 64'h15, 64'h1F, 1'b0, 1'b0);
        run_seq("stalls", 20, 1'b1, 1'b1, 2, 64'hF_5A3C, 64'hA_C35F, 1'b1, 1'b1);
        $display("%0d/%0d checks passed", total_checks - failed_checks, total_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total_checks++;
        failed_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total_checks - failed_checks, total_checks);
        $finish;
    end
endmodule